// File: doc/BRIEF.md
# Loss-of-Signal Detector

This block watches a recovered serial data stream, one bit for every pulse of a bit enable, and raises a loss-of-signal alarm when the line has gone quiet. A quiet line shows up as a long unbroken run of zero bits. The run length that declares the alarm is programmable. Clearing the alarm follows a different, separately programmed rule: enough ones must arrive inside one observation window, whose length is the same programmable interval.

Two outputs come out of the block. The first is the live alarm level. The second is a sticky interrupt flag that is set on each rising edge of the alarm and stays set until a one-cycle clear strobe. A simulation input forces the alarm high so that the alarm path can be exercised without a real line fault. When simulation ends, the alarm stays up until the normal recovery rule is satisfied. The bit enable may be gapped, and all counting advances only on enabled cycles.

Top module: `los_detector`

## Requirements
- R1: With the alarm clear, the alarm rises on the clock edge that samples the T-th consecutive enabled zero bit, and is visible from the following cycle. Any enabled one bit restarts the zero run, and an enabled one bit never raises the alarm.
- R2: Cycles with bit_en low do not count, whatever the level of bit_in. They neither advance nor restart the zero run or the recovery counts, and they leave the alarm unchanged.
- R3: The programmed interval is limited to the range 16 to 4096. A value below 16 acts as 16, and a value above 4096 acts as 4096.
- R4: While the alarm is set, recovery windows of T enabled bits follow one another. The first window starts with the first bit after the alarm rises. The alarm clears on the edge that samples the M-th enabled one inside a single window. The bit that completes a window still counts toward that window, and the ones count then restarts from zero.
- R5: The sticky flag los_irq is set on the same clock edge on which the alarm goes from low to high.
- R6: los_irq stays set until a cycle with irq_clr high, after which it reads 0. If a rising edge of the alarm falls on the same edge as the clear, the flag stays set.
- R7: While sim_en is high, the alarm is high from the next cycle on and stays high. Its rise sets los_irq in the normal way.
- R8: After sim_en drops, the alarm stays set until the recovery rule of R4 is met. Ones received while simulation was active do not count toward recovery.
- R9: After reset the alarm and los_irq are both 0, and all counts start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse marking a valid received bit |
| bit_in | input | 1 | Received data bit, sampled when bit_en is high |
| t_len | input | 13 | Interval T in bit periods (limited to 16..4096) |
| m_ones | input | 13 | Ones needed in one window to clear the alarm |
| sim_en | input | 1 | Alarm simulation, forces the alarm high |
| irq_clr | input | 1 | One-cycle clear strobe for los_irq |
| los | output | 1 | Live loss-of-signal alarm |
| los_irq | output | 1 | Sticky flag, set on each rising edge of los |

## Verification
The properties assume that m_ones lies between 1 and the effective interval. They also assume that m_ones and t_len are held steady while the alarm is up, because a threshold that moves in the middle of a window has no defined recovery point. The stimulus sets both values only right after a reset, or while the alarm is clear. It changes bit_in freely on idle cycles, so that the gapped-enable rule is exercised with ones as well as zeros.

// File: rtl/los_detector.sv
module los_detector #(
  parameter int TMIN = 16,
  parameter int TMAX = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_en,
  input  logic                          bit_in,
  input  logic [$clog2(TMAX+1)-1:0]     t_len,
  input  logic [$clog2(TMAX+1)-1:0]     m_ones,
  input  logic                          sim_en,
  input  logic                          irq_clr,
  output logic                          los,
  output logic                          los_irq
);
  localparam int CW = $clog2(TMAX+1);
  localparam logic [CW-1:0] T_LO  = CW'(TMIN);
  localparam logic [CW-1:0] T_HI  = CW'(TMAX);
  localparam logic [CW:0]   ONE_W = (CW+1)'(1);

  logic [CW-1:0] t_eff;
  logic [CW-1:0] zrun, win, ones;
  logic          los_q, los_nxt, irq_q;
  logic          zero_hit, enough_ones, win_end;

  assign t_eff = (t_len < T_LO) ? T_LO : ((t_len > T_HI) ? T_HI : t_len);

  assign zero_hit    = bit_en && !bit_in && (({1'b0, zrun} + ONE_W) >= {1'b0, t_eff});
  assign enough_ones = bit_en && bit_in && (({1'b0, ones} + ONE_W) >= {1'b0, m_ones});
  assign win_end     = (win == t_eff - CW'(1));

  always_comb begin
    if (sim_en)      los_nxt = 1'b1;
    else if (!los_q) los_nxt = zero_hit;
    else             los_nxt = !enough_ones;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun <= '0;
    end else if (bit_en) begin
      if (bit_in)              zrun <= '0;
      else if (zrun != t_eff)  zrun <= zrun + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      ones <= '0;
    end else if (!los_q || sim_en) begin
      win  <= '0;
      ones <= '0;
    end else if (bit_en) begin
      if (win_end) begin
        win  <= '0;
        ones <= '0;
      end else begin
        win  <= win + CW'(1);
        ones <= ones + CW'(bit_in);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      los_q <= los_nxt;
      irq_q <= (los_nxt && !los_q) || (irq_q && !irq_clr);
    end
  end

  assign los     = los_q;
  assign los_irq = irq_q;
endmodule

module los_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic bit_in,
  input logic sim_en,
  input logic irq_clr,
  input logic los,
  input logic los_irq
);
  AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $rose(los) |-> los_irq); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (los_irq && !irq_clr) |=> los_irq); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (irq_clr && los) |=> !los_irq); // R6
  AST_SIM_FORCES: assert property (@(posedge clk) disable iff (!rst_n) sim_en |=> los); // R7
  AST_ONE_NO_DECLARE: assert property (@(posedge clk) disable iff (!rst_n) (!los && !sim_en && bit_en && bit_in) |=> !los); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!bit_en && !sim_en) |=> $stable(los)); // R2
  AST_CLEAR_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n) (los && !(bit_en && bit_in)) |=> los); // R4
endmodule

bind los_detector los_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
  .sim_en(sim_en), .irq_clr(irq_clr), .los(los), .los_irq(los_irq)
);

// File: tb/tb_los_detector.sv
`timescale 1ns/1ps
module tb_los_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, bit_in = 1'b0, sim_en = 1'b0, irq_clr = 1'b0;
  logic [12:0] t_len = 13'd16, m_ones = 13'd4;
  logic        los, los_irq;
  int          checks = 0, errors = 0;

  typedef struct {
    bit    los;
    int    irq;
    string req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  los_detector dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .t_len(t_len), .m_ones(m_ones), .sim_en(sim_en), .irq_clr(irq_clr),
    .los(los), .los_irq(los_irq)
  );

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (los !== e.los) begin
        errors++;
        $display("FAIL %s: los=%0b expected %0b", e.req, los, e.los);
      end
      if (e.irq >= 0) begin
        checks++;
        if (los_irq !== e.irq[0]) begin
          errors++;
          $display("FAIL %s: los_irq=%0b expected %0d", e.req, los_irq, e.irq);
        end
      end
    end
  end

  task automatic step(input bit en, input bit b, input bit clr, input bit sim,
                      input bit elos, input int eirq, input string req);
    exp_t e;
    @(negedge clk);
    bit_en = en; bit_in = b; irq_clr = clr; sim_en = sim;
    e.los = elos; e.irq = eirq; e.req = req;
    q.push_back(e);
  endtask

  task automatic run(input int n, input bit en, input bit b, input bit elos, input string req);
    for (int i = 0; i < n; i++) step(en, b, 1'b0, 1'b0, elos, -1, req);
  endtask

  task automatic do_reset(input logic [12:0] t, input logic [12:0] m);
    @(negedge clk);
    bit_en = 0; bit_in = 0; irq_clr = 0; sim_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 0;
    t_len = t; m_ones = m;
    repeat (2) @(negedge clk);
    checks++;
    if (los !== 1'b0 || los_irq !== 1'b0) begin
      errors++;
      $display("FAIL R9: los=%0b los_irq=%0b expected 0 0", los, los_irq);
    end
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(13'd16, 13'd4);
    // R1 / R5: sixteen zeros declare
    run(15, 1, 0, 0, "R1");
    step(1, 0, 0, 0, 1, 1, "R5");
    // R4: three ones in a window are not enough; window restarts
    run(3, 1, 1, 1, "R4");
    run(13, 1, 0, 1, "R4");
    run(3, 1, 1, 1, "R4");
    step(1, 1, 0, 0, 0, 1, "R4");
    step(0, 0, 1, 0, 0, 0, "R6");
    // R1: a one restarts the zero run
    run(15, 1, 0, 0, "R1");
    step(1, 1, 0, 0, 0, 0, "R1");
    run(15, 1, 0, 0, "R1");
    step(1, 0, 0, 0, 1, 1, "R1");
    // R4: ones split across a window boundary do not add up
    run(14, 1, 0, 1, "R4");
    run(2, 1, 1, 1, "R4");
    run(2, 1, 1, 1, "R4");
    step(1, 1, 0, 0, 1, -1, "R4");
    step(1, 1, 0, 0, 0, -1, "R4");
    // R6: clear wins unless a rise coincides
    step(0, 0, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    run(15, 1, 0, 0, "R1");
    step(1, 0, 1, 0, 1, 1, "R6");
    step(0, 0, 0, 0, 1, 1, "R6");

    // R2: gapped enable
    do_reset(13'd16, 13'd4);
    run(10, 1, 0, 0, "R2");
    run(20, 0, 0, 0, "R2");
    run(5, 0, 1, 0, "R2");
    run(5, 1, 0, 0, "R2");
    step(1, 0, 0, 0, 1, 1, "R2");
    run(10, 0, 1, 1, "R2");
    run(3, 1, 1, 1, "R2");
    step(1, 1, 0, 0, 0, 1, "R2");

    // R3: interval limits
    do_reset(13'd5, 13'd4);
    run(15, 1, 0, 0, "R3");
    step(1, 0, 0, 0, 1, 1, "R3");
    do_reset(13'd8191, 13'd4);
    run(4095, 1, 0, 0, "R3");
    step(1, 0, 0, 0, 1, 1, "R3");

    // R7 / R8: simulation
    do_reset(13'd16, 13'd2);
    step(0, 0, 0, 1, 1, 1, "R7");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 1, -1, "R7");
    step(0, 0, 0, 0, 1, -1, "R8");
    step(1, 1, 0, 0, 1, -1, "R8");
    step(1, 1, 0, 0, 0, -1, "R8");

    @(negedge clk);
    bit_en = 0; bit_in = 0; irq_clr = 0; sim_en = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule